// File: doc/BRIEF.md
# Registered Eight-Operation Accumulator ALU

This block is the arithmetic and logic stage of a small accumulator datapath. It takes two 8-bit two's-complement operands: the accumulator value, which is held outside the block, and a data operand. A 3-bit operation code selects one of eight functions. The result is captured in an output register on each rising clock edge. The block itself keeps no accumulator state.

A separate flag output is not registered. It tells, within the same cycle, whether the accumulator operand presented right now is zero. Surrounding control logic can use it for conditional decisions without waiting for a clock edge.

Top module: `acc_alu8`

## Requirements
- R1: The result output `res_q` changes only at a rising edge of `clk`. Any change on `acc_in`, `opd_in` or `op_sel` between edges leaves `res_q` unchanged until the next rising edge.
- R2: Reset is active high and synchronous. When `rst` is high at a rising edge, `res_q` becomes 0 at that edge, whatever the operands and code are.
- R3: `acc_is_zero` is combinational. It is 1 exactly when `acc_in` equals 0, it follows `acc_in` within the same cycle, and it does not depend on `opd_in`, `op_sel` or `rst`.
- R4: Code 3'b000 loads `acc_in` unchanged. Code 3'b111 loads `opd_in` unchanged.
- R5: Code 3'b001 loads `acc_in + opd_in`, wrapped modulo 256 with no carry kept.
- R6: Code 3'b010 loads `acc_in - opd_in`, wrapped modulo 256 with no borrow kept.
- R7: Code 3'b011 loads the bitwise AND of the operands. Code 3'b100 loads their bitwise XOR.
- R8: Code 3'b101 loads the absolute value of `acc_in`, with bit 7 taken as the sign. A value with bit 7 clear passes unchanged, a value with bit 7 set is negated, and 8'h80 gives 8'h80.
- R9: Code 3'b110 loads the two's-complement negation of `acc_in` (modulo 256). 8'h00 gives 8'h00 and 8'h80 gives 8'h80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the result register |
| acc_in | input | 8 | Accumulator operand, two's complement |
| opd_in | input | 8 | Data operand, two's complement |
| op_sel | input | 3 | Operation code |
| res_q | output | 8 | Registered result |
| acc_is_zero | output | 1 | High while `acc_in` is zero |

## Verification
The assertions assume that `op_sel` and both operands carry known values at every rising edge and are held steady around that edge. They also assume `rst` is the only source of the zero result that appears after a reset edge. The stimulus meets these assumptions by changing every input half a period away from the rising edge. It always drives defined values and walks all eight codes, each with operands chosen for sign boundaries such as 8'h00, 8'h7F, 8'h80 and 8'hFF. Reset is asserted only while the bench is deliberately loading non-zero operands, so that clearing the register is actually observed.

// File: rtl/alu_pkg.sv
package alu_pkg;

    parameter int ALU_W = 8;

    typedef enum logic [2:0] {
        OP_PASS_ACC = 3'b000,
        OP_ADD      = 3'b001,
        OP_SUB      = 3'b010,
        OP_AND      = 3'b011,
        OP_XOR      = 3'b100,
        OP_ABS      = 3'b101,
        OP_NEG      = 3'b110,
        OP_PASS_OPD = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic      use_adder;
        logic      invert_b;
        alu_op_e   op;
    } alu_ctl_t;

    function automatic alu_ctl_t decode_op(input logic [2:0] code);
        alu_ctl_t c;
        c.op        = alu_op_e'(code);
        c.use_adder = (code == OP_ADD) || (code == OP_SUB);
        c.invert_b  = (code == OP_SUB);
        return c;
    endfunction

endpackage

// File: rtl/alu_zero_det.sv
module alu_zero_det #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    output logic         is_zero
);
    assign is_zero = ~|val;
endmodule

// File: rtl/alu_op_unit.sv
module alu_op_unit
    import alu_pkg::*;
#(
    parameter int W              = 8,
    parameter bit SHARED_ADDSUB  = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_ctl_t     ctl,
    output logic [W-1:0] y
);
    localparam int SIGN = W - 1;

    logic [W-1:0] addsub;
    logic [W-1:0] neg_a;
    logic [W-1:0] abs_a;

    generate
        if (SHARED_ADDSUB) begin : g_shared
            logic [W-1:0] b_eff;
            assign b_eff  = ctl.invert_b ? ~b : b;
            assign addsub = a + b_eff + {{(W-1){1'b0}}, ctl.invert_b};
        end else begin : g_split
            logic [W-1:0] sum_v;
            logic [W-1:0] dif_v;
            assign sum_v  = a + b;
            assign dif_v  = a - b;
            assign addsub = ctl.invert_b ? dif_v : sum_v;
        end
    endgenerate

    assign neg_a = ~a + {{(W-1){1'b0}}, 1'b1};
    assign abs_a = a[SIGN] ? neg_a : a;

    always_comb begin
        case (ctl.op)
            OP_PASS_ACC: y = a;
            OP_ADD,
            OP_SUB:      y = addsub;
            OP_AND:      y = a & b;
            OP_XOR:      y = a ^ b;
            OP_ABS:      y = abs_a;
            OP_NEG:      y = neg_a;
            OP_PASS_OPD: y = b;
            default:     y = a;
        endcase
    end
endmodule

// File: rtl/alu_out_reg.sv
module alu_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R2
    AST_LOADS_INPUT: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (q == $past(d))); // R1
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opd_in,
    input  logic [2:0]   op_sel,
    output logic [W-1:0] res_q,
    output logic         acc_is_zero
);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    alu_ctl_t     ctl;
    logic [W-1:0] next_res;

    assign ctl = decode_op(op_sel);

    alu_op_unit #(.W(W), .SHARED_ADDSUB(1'b1)) u_ops (
        .a   (acc_in),
        .b   (opd_in),
        .ctl (ctl),
        .y   (next_res)
    );

    alu_out_reg #(.W(W)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (next_res),
        .q   (res_q)
    );

    alu_zero_det #(.W(W)) u_zero (
        .val     (acc_in),
        .is_zero (acc_is_zero)
    );

    AST_PASS_OPD: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b111) |=> (res_q == $past(opd_in))); // R4
    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (acc_is_zero && op_sel == 3'b000) |=> (res_q == '0)); // R3
    AST_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b001) |=> (res_q == W'($past(acc_in) + $past(opd_in)))); // R5
    AST_SUB_WRAP: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b010) |=> (W'(res_q + $past(opd_in)) == $past(acc_in))); // R6
    AST_NEG_SUM: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b110) |=> (W'(res_q + $past(acc_in)) == '0)); // R9
    AST_ABS_SIGN: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b101 && acc_in != MIN_NEG) |=> !res_q[W-1]); // R8
    AST_XOR_SELF: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b100) |=> ((res_q ^ $past(opd_in)) == $past(acc_in))); // R7
endmodule

// File: tb/acc_alu8_bench.sv
module acc_alu8_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc_in = '0;
    logic [7:0] opd_in = '0;
    logic [2:0] op_sel = '0;
    logic [7:0] res_q;
    logic       acc_is_zero;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    acc_alu8 u_acc_alu8 (
        .clk(clk), .rst(rst), .acc_in(acc_in), .opd_in(opd_in),
        .op_sel(op_sel), .res_q(res_q), .acc_is_zero(acc_is_zero)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b,
                                         input logic [2:0] op);
        case (op)
            3'd0: return a;
            3'd1: return 8'((a + b) % 256);
            3'd2: return 8'((256 + a - b) % 256);
            3'd3: return a & b;
            3'd4: return a ^ b;
            3'd5: return (a >= 8'd128) ? 8'((256 - a) % 256) : a;
            3'd6: return 8'((256 - a) % 256);
            default: return b;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [7:0] a, input logic [7:0] b,
                          input logic [2:0] op);
        @(negedge clk);
        acc_in = a; opd_in = b; op_sel = op;
        @(posedge clk); #1;
        check(req, res_q, model(a, b, op));
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; acc_in = 8'h5A; opd_in = 8'h33; op_sel = 3'd7;
        @(posedge clk); #1;
        check("R2 reset clears", res_q, 8'h00);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R2 release loads", res_q, 8'h33);
        @(negedge clk); rst = 1'b1; op_sel = 3'd1;
        @(posedge clk); #1;
        check("R2 reset over op", res_q, 8'h00);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_registered;
        run_op("R1 setup", 8'h11, 8'h22, 3'd1);
        @(negedge clk);
        acc_in = 8'h40; opd_in = 8'h01; op_sel = 3'd3;
        #2;
        check("R1 no change before edge", res_q, 8'h33);
        @(posedge clk); #1;
        check("R1 update at edge", res_q, 8'h00);
    endtask

    task automatic t_zero;
        @(negedge clk);
        acc_in = 8'h00; opd_in = 8'hFF; op_sel = 3'd1; #1;
        check("R3 zero high", {7'd0, acc_is_zero}, 8'd1);
        acc_in = 8'h80; #1;
        check("R3 zero low same cycle", {7'd0, acc_is_zero}, 8'd0);
        acc_in = 8'h00; opd_in = 8'h00; op_sel = 3'd6; #1;
        check("R3 independent of others", {7'd0, acc_is_zero}, 8'd1);
        acc_in = 8'h01; #1;
        check("R3 one is nonzero", {7'd0, acc_is_zero}, 8'd0);
    endtask

    task automatic t_pass;
        run_op("R4 pass acc", 8'hC3, 8'h3C, 3'd0);
        run_op("R4 pass data", 8'hC3, 8'h3C, 3'd7);
    endtask

    task automatic t_add;
        run_op("R5 add", 8'h12, 8'h34, 3'd1);
        run_op("R5 add wrap", 8'hFF, 8'h02, 3'd1);
        run_op("R5 add signed", 8'h7F, 8'h01, 3'd1);
    endtask

    task automatic t_sub;
        run_op("R6 sub", 8'h50, 8'h20, 3'd2);
        run_op("R6 sub wrap", 8'h00, 8'h01, 3'd2);
        run_op("R6 sub min", 8'h80, 8'h01, 3'd2);
    endtask

    task automatic t_logic;
        run_op("R7 and", 8'hF0, 8'h3C, 3'd3);
        run_op("R7 xor", 8'hF0, 8'h3C, 3'd4);
        run_op("R7 xor self", 8'hA5, 8'hA5, 3'd4);
    endtask

    task automatic t_abs;
        run_op("R8 abs pos", 8'h7F, 8'h00, 3'd5);
        run_op("R8 abs neg", 8'hFB, 8'h00, 3'd5);
        run_op("R8 abs min", 8'h80, 8'h00, 3'd5);
        run_op("R8 abs zero", 8'h00, 8'h55, 3'd5);
    endtask

    task automatic t_neg;
        run_op("R9 neg", 8'h05, 8'h00, 3'd6);
        run_op("R9 neg zero", 8'h00, 8'h00, 3'd6);
        run_op("R9 neg min", 8'h80, 8'h00, 3'd6);
        run_op("R9 neg neg", 8'hFF, 8'h00, 3'd6);
    endtask

    task automatic t_sweep;
        for (int op = 0; op < 8; op++) begin
            run_op("R4-sweep", 8'h9C, 8'h27, 3'(op));
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R2 reset state", res_q, 8'h00);
        t_reset();
        t_registered();
        t_zero();
        t_pass();
        t_add();
        t_sub();
        t_logic();
        t_abs();
        t_neg();
        t_sweep();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule